// File: doc/BRIEF.md
# I2C Subaddressed Register Bridge

This block is an I2C slave that sits between a two-wire host bus and an internal word-wide resource. After the slave matches its 7-bit device address, the next byte is a subaddress that picks one of two targets. Subaddress 0x00 is a 16-bit control/status register inside the bridge. Subaddress 0x01 is an indirect memory port: the host sends a 16-bit word address and then 16 bits of data, or for a read it sends the address and then reads the word back after a repeated START.

Accesses to the memory port go to the back end through a request/acknowledge handshake. While a request is outstanding, the bridge holds SCL low so the host waits. A stretch that lasts longer than a parameterized cycle count is abandoned: the byte is not acknowledged, and a sticky error flag is set. While that flag is set, the memory subaddress is refused. The control subaddress still works, so the host can read the flags, and that read clears them. Both bus lines are sampled through synchronizers. The bridge drives the bus only through output enables for open-drain pads.

Top module: `i2c_subreg_bridge`

## Requirements
- R1: After reset the bridge drives neither line and has no memory request pending. The first control read returns 0x8000: bit 15 is the reset-seen flag, set at power-on; bit 14 is the error flag, clear; bits 13:0 always read 0.
- R2: Reading the control register clears bits 15 and 14. A second read with no event in between returns 0x0000.
- R3: A byte after START whose upper 7 bits differ from DEV_ADDR gets no acknowledge, and no memory request follows.
- R4: A memory write (address+W, 0x01, address high, address low, data high, data low) acknowledges every byte. After the last data byte the bridge stretches SCL and raises mem_req with mem_we=1, the address and the data. It acknowledges that byte only after mem_ack.
- R5: A memory read (address+W, 0x01, address high, address low, repeated START, address+R) stretches SCL after the read address byte. It requests with mem_we=0 and then shifts out the returned word, high byte first, MSB first.
- R6: A control write (address+W, 0x00, high, low) with data bit 15 = 1 produces exactly one single-cycle soft_rst pulse and sets the reset-seen flag. A write with bit 15 = 0 produces no pulse.
- R7: A subaddress other than 0x00 and 0x01 is not acknowledged.
- R8: If mem_ack has not arrived STRETCH_LIMIT cycles into a stretch, the bridge drops the request and releases SCL. It leaves the pending byte unacknowledged, and control bit 14 reads 1 afterwards.
- R9: While control bit 14 is set, subaddress 0x01 is not acknowledged but subaddress 0x00 still is. After the flag has been read, memory accesses succeed again.
- R10: SCL is held low for the whole time a memory request is outstanding. The request, address and direction stay stable until mem_ack or the timeout.
- R11: When the host NAKs the high data byte of a read, the bridge stops driving SDA. Further clocks before the next START read as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge or data 0) |
| mem_req | output | 1 | Memory access request, held until mem_ack or timeout |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address of the memory access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Single-cycle completion of the request |
| soft_rst | output | 1 | One-cycle pulse on a control write with bit 15 set |

## Verification
A wrong byte-phase state shows up on the very next acknowledge slot: the host sees a NAK, or an ACK where none is due, within nine SCL periods of the fault. Corrupted address or data registers show up on mem_addr and mem_wdata at the next request, or as a wrong word when that location is read back. Flag errors in the control register only become visible at the following control read, so reads are placed right after every event that should set or clear a flag. A broken stretch timer appears either as a hang, which the watchdog catches, or as a stretch length far from STRETCH_LIMIT.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  typedef enum logic [3:0] {
    B_IDLE, B_DEV, B_SUB, B_AH, B_AL, B_DH, B_DL, B_TXH, B_TXL, B_DONE
  } byte_st_t;

  typedef enum logic [1:0] {P_BITS, P_ACK, P_WAIT, P_MACK} phase_t;

  typedef enum logic [1:0] {A_ACK, A_NAK, A_WAIT} act_t;

  localparam logic [7:0] SUB_CTRL = 8'h00;
  localparam logic [7:0] SUB_MEM  = 8'h01;

  // control register read image: flags on top, remaining bits zero
  function automatic logic [15:0] ctrl_image(input logic rst_seen, input logic err_seen);
    return {rst_seen, err_seen, 14'b0};
  endfunction

  function automatic logic dev_match(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

endpackage

// File: rtl/i2cb_line_sync.sv
module i2cb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin scl_p <= '1; sda_p <= '1; end
        else begin scl_p[0] <= scl_i; sda_p[0] <= sda_i; end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin scl_p <= '1; sda_p <= '1; end
        else begin
          scl_p <= {scl_p[STAGES-2:0], scl_i};
          sda_p <= {sda_p[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  assign scl_s = scl_p[STAGES-1];
  assign sda_s = sda_p[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin scl_d <= 1'b1; sda_d <= 1'b1; end
    else begin scl_d <= scl_s; sda_d <= sda_s; end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cb_stretch_timer.sv
module i2cb_stretch_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (!active) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;

  assign expired = active && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/i2cb_ctrl_reg.sv
module i2cb_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_rst_i,
  input  logic err_set_i,
  input  logic rd_clr_i,
  output logic rst_flag_o,
  output logic err_flag_o,
  output logic soft_rst_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_flag_o <= 1'b1;
      err_flag_o <= 1'b0;
    end else begin
      if (wr_rst_i)      rst_flag_o <= 1'b1;
      else if (rd_clr_i) rst_flag_o <= 1'b0;
      if (err_set_i)     err_flag_o <= 1'b1;
      else if (rd_clr_i) err_flag_o <= 1'b0;
    end

  assign soft_rst_o = wr_rst_i;
endmodule

// File: rtl/i2c_subreg_bridge.sv
module i2c_subreg_bridge
  import i2cb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR      = 7'h42,
  parameter int         STRETCH_LIMIT = 100000,
  parameter int         SYNC_STAGES   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_ack,
  output logic        soft_rst
);
  localparam int BITS_PER_BYTE = 8;
  localparam int BCW = $clog2(BITS_PER_BYTE + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic tmo_w, rst_flag, err_flag;
  logic wr_rst_q, err_set_q, rd_clr_q;

  byte_st_t        st, dec_next;
  phase_t          ph;
  act_t            dec_act;
  logic [BCW-1:0]  bitcnt;
  logic [7:0]      rx_sh, tx_sh, sub_q;
  logic [15:0]     addr_q, wdat_q, tx_word;
  logic            have_addr, mack_q, is_tx, byte_done;

  i2cb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cb_stretch_timer #(.LIMIT(STRETCH_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .active(ph == P_WAIT && st != B_IDLE), .expired(tmo_w)
  );

  i2cb_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_rst_i(wr_rst_q), .err_set_i(err_set_q),
    .rd_clr_i(rd_clr_q), .rst_flag_o(rst_flag), .err_flag_o(err_flag),
    .soft_rst_o(soft_rst)
  );

  assign is_tx     = (st == B_TXH) || (st == B_TXL);
  assign byte_done = scl_fall && (bitcnt == BCW'(BITS_PER_BYTE));
  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;

  // decision taken at the end of each received byte
  always_comb begin
    dec_act  = A_NAK;
    dec_next = B_IDLE;
    case (st)
      B_DEV: if (dev_match(rx_sh, DEV_ADDR)) begin
        if (!rx_sh[0]) begin dec_act = A_ACK; dec_next = B_SUB; end
        else if (sub_q == SUB_CTRL) begin dec_act = A_ACK; dec_next = B_TXH; end
        else if (sub_q == SUB_MEM && have_addr && !err_flag) begin
          dec_act = A_WAIT; dec_next = B_TXH;
        end
      end
      B_SUB: if (rx_sh == SUB_CTRL) begin dec_act = A_ACK; dec_next = B_DH; end
             else if (rx_sh == SUB_MEM && !err_flag) begin dec_act = A_ACK; dec_next = B_AH; end
      B_AH: begin dec_act = A_ACK; dec_next = B_AL; end
      B_AL: begin dec_act = A_ACK; dec_next = B_DH; end
      B_DH: begin dec_act = A_ACK; dec_next = B_DL; end
      B_DL: begin dec_act = (sub_q == SUB_MEM) ? A_WAIT : A_ACK; dec_next = B_DONE; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= B_IDLE; ph <= P_BITS; bitcnt <= '0;
      rx_sh <= '0; tx_sh <= '0; sub_q <= SUB_CTRL;
      addr_q <= '0; wdat_q <= '0; tx_word <= '0;
      have_addr <= 1'b0; mack_q <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; mem_req <= 1'b0; mem_we <= 1'b0;
      wr_rst_q <= 1'b0; err_set_q <= 1'b0; rd_clr_q <= 1'b0;
    end else begin
      wr_rst_q <= 1'b0; err_set_q <= 1'b0; rd_clr_q <= 1'b0;
      if (start_det) begin
        st <= B_DEV; ph <= P_BITS; bitcnt <= '0;
        sda_oe <= 1'b0; scl_oe <= 1'b0;
      end else if (stop_det) begin
        st <= B_IDLE; ph <= P_BITS; have_addr <= 1'b0;
        sda_oe <= 1'b0; scl_oe <= 1'b0;
      end else if (st != B_IDLE) begin
        case (ph)
          P_BITS: if (is_tx) begin
            if (scl_rise) bitcnt <= bitcnt + 1'b1;
            if (byte_done) begin
              sda_oe <= 1'b0; ph <= P_MACK;
            end else if (scl_fall) begin
              tx_sh <= {tx_sh[6:0], 1'b0}; sda_oe <= ~tx_sh[6];
            end
          end else begin
            if (scl_rise) begin rx_sh <= {rx_sh[6:0], sda_s}; bitcnt <= bitcnt + 1'b1; end
            if (byte_done) begin
              bitcnt <= '0;
              case (st)
                B_SUB: sub_q <= rx_sh;
                B_AH:  addr_q[15:8] <= rx_sh;
                B_AL:  begin addr_q[7:0] <= rx_sh; have_addr <= 1'b1; end
                B_DH:  wdat_q[15:8] <= rx_sh;
                B_DL:  begin
                  wdat_q[7:0] <= rx_sh;
                  if (sub_q == SUB_CTRL && wdat_q[15]) wr_rst_q <= 1'b1;
                end
                B_DEV: if (dec_act == A_ACK && rx_sh[0]) begin
                  tx_word <= ctrl_image(rst_flag, err_flag); rd_clr_q <= 1'b1;
                end
                default: ;
              endcase
              case (dec_act)
                A_ACK:  begin sda_oe <= 1'b1; ph <= P_ACK; st <= dec_next; end
                A_WAIT: begin
                  scl_oe <= 1'b1; mem_req <= 1'b1; mem_we <= (st == B_DL);
                  ph <= P_WAIT; st <= dec_next;
                end
                default: begin sda_oe <= 1'b0; st <= B_IDLE; end
              endcase
            end
          end
          P_ACK: if (scl_fall) begin
            bitcnt <= '0; ph <= P_BITS;
            if (st == B_TXH) begin tx_sh <= tx_word[15:8]; sda_oe <= ~tx_word[15]; end
            else sda_oe <= 1'b0;
          end
          P_WAIT: if (mem_ack) begin
            mem_req <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b1; ph <= P_ACK;
            if (!mem_we) tx_word <= mem_rdata;
          end else if (tmo_w) begin
            mem_req <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
            err_set_q <= 1'b1; ph <= P_BITS; st <= B_IDLE;
          end
          default: begin // P_MACK
            if (scl_rise) mack_q <= ~sda_s;
            if (scl_fall) begin
              bitcnt <= '0; ph <= P_BITS;
              if (st == B_TXH && mack_q) begin
                st <= B_TXL; tx_sh <= tx_word[7:0]; sda_oe <= ~tx_word[7];
              end else st <= B_IDLE;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cb_assert.sv
module i2cb_assert (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic        mem_ack,
  input logic        soft_rst,
  input logic        tmo
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!mem_req && !scl_oe && !sda_oe));

  a_r10_stretch_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> scl_oe);

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !tmo) |=> mem_req);

  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> ($stable(mem_addr) && $stable(mem_we)));

  a_r6_soft_single: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  a_r8_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (!mem_req && !scl_oe && !sda_oe));
endmodule

bind i2c_subreg_bridge i2cb_assert u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .soft_rst(soft_rst), .tmo(tmo_w)
);

// File: tb/i2c_subreg_bridge_test.sv
module i2c_subreg_bridge_test;
  localparam logic [6:0] DEV = 7'h42;
  localparam int LIMIT = 400;
  localparam int LAT   = 25;
  localparam int Q     = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, mem_req, mem_we, mem_ack, soft_rst;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  wire scl_ln = scl_m & ~scl_oe;
  wire sda_ln = sda_m & ~sda_oe;

  i2c_subreg_bridge #(.DEV_ADDR(DEV), .STRETCH_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .soft_rst(soft_rst)
  );

  int total = 0, bad = 0, cyc = 0, soft_cnt = 0, req_cnt = 0;
  bit mem_dead = 1'b0;
  int lat_cnt = 0;
  logic [15:0] mem_arr [0:255];
  logic last_we;
  logic [15:0] last_addr, last_wdata;

  assign mem_rdata = mem_arr[mem_addr[7:0]];

  initial begin
    for (int i = 0; i < 256; i++) mem_arr[i] = 16'h0;
    mem_ack = 1'b0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (soft_rst) soft_cnt <= soft_cnt + 1;
    if (!mem_req) begin lat_cnt <= 0; mem_ack <= 1'b0; end
    else if (mem_ack) mem_ack <= 1'b0;
    else if (!mem_dead) begin
      if (lat_cnt == LAT) begin
        mem_ack <= 1'b1; req_cnt <= req_cnt + 1;
        last_we <= mem_we; last_addr <= mem_addr; last_wdata <= mem_wdata;
        if (mem_we) mem_arr[mem_addr[7:0]] <= mem_wdata;
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  always @(negedge clk)
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic scl_up(output int st);
    st = 0;
    scl_m = 1'b1;
    @(negedge clk);
    while (!scl_ln) begin @(negedge clk); st++; end
    qwait();
  endtask

  task automatic i2c_start();
    int s;
    sda_m = 1'b1; qwait();
    scl_up(s);
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic i2c_stop();
    int s;
    sda_m = 1'b0; qwait();
    scl_up(s);
    sda_m = 1'b1; qwait();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack, output int stretch);
    int s;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qwait();
      scl_up(s);
      scl_m = 1'b0; qwait();
    end
    sda_m = 1'b1; qwait();
    scl_up(stretch);
    ack = !sda_ln;
    scl_m = 1'b0; qwait();
  endtask

  task automatic rbyte(input bit nak, output logic [7:0] b);
    int s;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait();
      scl_up(s);
      b[i] = sda_ln;
      scl_m = 1'b0;
    end
    qwait();
    sda_m = nak; qwait();
    scl_up(s);
    scl_m = 1'b0; qwait();
    sda_m = 1'b1;
  endtask

  task automatic ctrl_read(output logic [15:0] v, output logic [2:0] acks);
    int s; bit a;
    i2c_start();
    wbyte({DEV, 1'b0}, a, s); acks[2] = a;
    wbyte(8'h00, a, s); acks[1] = a;
    i2c_start();
    wbyte({DEV, 1'b1}, a, s); acks[0] = a;
    rbyte(1'b0, v[15:8]);
    rbyte(1'b1, v[7:0]);
    i2c_stop();
  endtask

  task automatic ctrl_write(input logic [15:0] v, output logic [3:0] acks);
    int s; bit a;
    i2c_start();
    wbyte({DEV, 1'b0}, a, s); acks[3] = a;
    wbyte(8'h00, a, s); acks[2] = a;
    wbyte(v[15:8], a, s); acks[1] = a;
    wbyte(v[7:0], a, s); acks[0] = a;
    i2c_stop();
  endtask

  task automatic mem_write(input logic [15:0] ad, input logic [15:0] d,
                           output logic [5:0] acks, output int stretch);
    int s; bit a;
    i2c_start();
    wbyte({DEV, 1'b0}, a, s); acks[5] = a;
    wbyte(8'h01, a, s); acks[4] = a;
    wbyte(ad[15:8], a, s); acks[3] = a;
    wbyte(ad[7:0], a, s); acks[2] = a;
    wbyte(d[15:8], a, s); acks[1] = a;
    wbyte(d[7:0], a, stretch); acks[0] = a;
    i2c_stop();
  endtask

  task automatic mem_read(input logic [15:0] ad, input bit nak_hi, output logic [15:0] d,
                          output logic [4:0] acks, output int stretch);
    int s; bit a;
    i2c_start();
    wbyte({DEV, 1'b0}, a, s); acks[4] = a;
    wbyte(8'h01, a, s); acks[3] = a;
    wbyte(ad[15:8], a, s); acks[2] = a;
    wbyte(ad[7:0], a, s); acks[1] = a;
    i2c_start();
    wbyte({DEV, 1'b1}, a, stretch); acks[0] = a;
    rbyte(nak_hi, d[15:8]);
    rbyte(1'b1, d[7:0]);
    i2c_stop();
  endtask

  // {is_read, address, data or expected data}
  localparam logic [32:0] VEC [0:5] = '{
    {1'b0, 16'h0010, 16'hA55A},
    {1'b0, 16'h00F3, 16'h1234},
    {1'b1, 16'h0010, 16'hA55A},
    {1'b1, 16'h00F3, 16'h1234},
    {1'b0, 16'h0010, 16'h0FF0},
    {1'b1, 16'h0010, 16'h0FF0}
  };

  initial begin
    logic [15:0] v;
    logic [5:0] a6; logic [4:0] a5; logic [3:0] a4; logic [2:0] a3;
    int s, rq, sc;
    bit a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state and power-on flag
    chk("R1 idle outputs", {29'b0, scl_oe, sda_oe, mem_req}, 32'h0);
    ctrl_read(v, a3);
    chk("R1 ctrl acks", {29'b0, a3}, 32'h7);
    chk("R1 ctrl after reset", {16'h0, v}, 32'h8000);
    // R2 clear on read
    ctrl_read(v, a3);
    chk("R2 ctrl cleared", {16'h0, v}, 32'h0000);

    // R3 foreign device address
    rq = req_cnt;
    i2c_start();
    wbyte({7'h13, 1'b0}, a, s);
    wbyte(8'h01, a, s);
    i2c_stop();
    chk("R3 foreign addr nak", {31'b0, a}, 32'h0);
    chk("R3 no request", rq, req_cnt);

    // table-driven memory traffic (R4, R5)
    for (int k = 0; k < 6; k++) begin
      if (!VEC[k][32]) begin
        mem_write(VEC[k][31:16], VEC[k][15:0], a6, s);
        chk("R4 write acks", {26'b0, a6}, 32'h3F);
        chk("R4 write stretched", {31'b0, s > 5}, 32'h1);
        chk("R4 write req", {15'b0, last_we, last_addr}, {15'b0, 1'b1, VEC[k][31:16]});
        chk("R4 write data", {16'h0, last_wdata}, {16'h0, VEC[k][15:0]});
      end else begin
        mem_read(VEC[k][31:16], 1'b0, v, a5, s);
        chk("R5 read acks", {27'b0, a5}, 32'h1F);
        chk("R5 read stretched", {31'b0, s > 5}, 32'h1);
        chk("R5 read dir", {31'b0, last_we}, 32'h0);
        chk("R5 read data", {16'h0, v}, {16'h0, VEC[k][15:0]});
      end
    end

    // R7 unknown subaddress
    i2c_start();
    wbyte({DEV, 1'b0}, a, s);
    wbyte(8'h07, a, s);
    i2c_stop();
    chk("R7 bad sub nak", {31'b0, a}, 32'h0);

    // R6 soft reset write
    sc = soft_cnt;
    ctrl_write(16'h8000, a4);
    repeat (3) @(negedge clk);
    chk("R6 write acks", {28'b0, a4}, 32'hF);
    chk("R6 one pulse", soft_cnt - sc, 1);
    ctrl_read(v, a3);
    chk("R6 flag set", {16'h0, v}, 32'h8000);
    sc = soft_cnt;
    ctrl_write(16'h0000, a4);
    repeat (3) @(negedge clk);
    chk("R6 no pulse on 0", soft_cnt - sc, 0);
    ctrl_read(v, a3);
    chk("R6 flag stays clear", {16'h0, v}, 32'h0000);

    // R11 master NAK after high byte, then extra clocks read all ones
    i2c_start();
    wbyte({DEV, 1'b0}, a, s);
    wbyte(8'h01, a, s);
    wbyte(8'h00, a, s);
    wbyte(8'hF3, a, s);
    i2c_start();
    wbyte({DEV, 1'b1}, a, s);
    rbyte(1'b1, v[15:8]);
    rbyte(1'b1, v[7:0]);
    i2c_stop();
    chk("R11 high byte", {24'h0, v[15:8]}, 32'h12);
    chk("R11 released after nak", {24'h0, v[7:0]}, 32'hFF);

    // R8 stretch timeout
    mem_dead = 1'b1;
    mem_write(16'h0020, 16'hBEEF, a6, s);
    mem_dead = 1'b0;
    chk("R8 timeout acks", {26'b0, a6}, 32'h3E);
    chk("R8 stretch length", {31'b0, (s >= LIMIT - 20) && (s <= LIMIT + 5)}, 32'h1);
    chk("R8 memory untouched", {16'h0, mem_arr[8'h20]}, 32'h0);

    // R9 memory locked out while error flag set
    mem_write(16'h0021, 16'h5555, a6, s);
    chk("R9 sub refused", {26'b0, a6}, 32'h20);
    ctrl_read(v, a3);
    chk("R9 ctrl still acks", {29'b0, a3}, 32'h7);
    chk("R8 error flag", {16'h0, v}, 32'h4000);
    mem_write(16'h0021, 16'h5555, a6, s);
    chk("R9 memory back", {26'b0, a6}, 32'h3F);
    mem_read(16'h0021, 1'b0, v, a5, s);
    chk("R9 readback", {16'h0, v}, 32'h5555);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule